// File: doc/BRIEF.md
# Home-Node Directory Coherence Controller

This block sits at the home node of a coherent memory shared by `NUM_PROC` processors. It stores one data word per memory block together with a directory entry, which holds a sharer vector with one bit per processor and a single dirty flag. Processors send it read requests, write requests (fetch with exclusive ownership) and eviction write-backs. Each request carries the requester's index. The controller does not broadcast. It sends point-to-point messages only to the processors that the directory names. These are invalidations to the sharers when a clean line is written, and a recall to the single owner when a dirty line is requested. It counts the replies, takes recalled data into memory and then answers the requester.

The controller handles one transaction at a time. It holds `req_ready_o` low from the moment it accepts a request until the cycle in which it answers. Transactions to the same block are therefore always serialized. Outgoing messages go out one per cycle in ascending processor order. The interconnect is assumed to take every message in the cycle it is offered.

Top module: `coh_home_dir`

## Requirements
- R1: After reset every block holds data 0, has an empty sharer vector and is clean, `req_ready_o` is 1, and `rsp_valid_o` and `msg_valid_o` are 0.
- R2: A read (op 0) of a clean block sends no message, answers with the stored word and adds the requester to the sharers.
- R3: A read of a dirty block owned by another processor sends exactly one recall-to-shared message (kind 1) to the owner. It answers with the word carried by the owner's reply and stores that word in memory. The block becomes clean, and both the old owner and the requester are left as sharers.
- R4: A write (op 1) to a clean block sends one invalidation (kind 0) to each sharer other than the requester, one per cycle in ascending index order. No message goes to any other processor.
- R5: The answer to a request that sent messages is given only after a reply has arrived for every message sent. It appears in the cycle after the last reply.
- R6: After a write completes, the requester is the only sharer and the block is dirty. A later read by another processor therefore recalls from the writer alone.
- R7: A write to a dirty block owned by another processor sends exactly one recall-with-invalidate message (kind 2) to the owner. It answers with the recalled word, stores that word in memory and transfers ownership to the requester. The old owner is no longer recorded as a sharer.
- R8: A write-back (op 2) from the owner of a dirty block stores its data, clears the dirty flag and removes the owner from the sharers. No message is sent.
- R9: A write-back from a processor that does not own the block as dirty changes neither memory nor the directory.
- R10: Every accepted request gets exactly one single-cycle answer on `rsp_valid_o`, addressed to the requester. `req_ready_o` stays 0 from the cycle after acceptance until that answer, and returns to 1 in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Controller idle and able to accept |
| req_op_i | input | 2 | 0 read, 1 write, 2 write-back |
| req_src_i | input | PID_W | Requesting processor index |
| req_blk_i | input | BLK_W | Block index |
| req_data_i | input | DATA_W | Write-back data |
| msg_valid_o | output | 1 | Coherence message present this cycle |
| msg_kind_o | output | 2 | 0 invalidate, 1 recall to shared, 2 recall with invalidate |
| msg_dst_o | output | PID_W | Destination processor |
| ack_valid_i | input | 1 | Reply to one earlier message |
| ack_data_i | input | DATA_W | Data carried by a recall reply |
| rsp_valid_o | output | 1 | Answer to the requester, one cycle |
| rsp_dst_o | output | PID_W | Processor being answered |
| rsp_data_o | output | DATA_W | Line data returned |

## Verification
The assertions assume that replies arrive only for messages already sent, at most one per cycle and exactly one per message. They also assume that a processor never issues a read or write to a block it already holds dirty. The bench models each processor's reply path so that it answers each recorded message once, in send order, and can hold the replies back by a chosen number of cycles to expose early answers. The request sequence is chosen so that no requester ever targets a line it already owns.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [1:0] {OP_RD = 2'd0, OP_WR = 2'd1, OP_WB = 2'd2} op_e;
  typedef enum logic [1:0] {MSG_INV = 2'd0, MSG_RCL_SH = 2'd1, MSG_RCL_INV = 2'd2} msg_e;
  typedef enum logic [1:0] {ST_IDLE, ST_BUSY, ST_DONE} state_e;
endpackage

// File: rtl/coh_first_set.sv
module coh_first_set #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0]     vec_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [N-1:0]     onehot_o
);
  always_comb begin
    found_o  = 1'b0;
    idx_o    = '0;
    onehot_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        found_o  = 1'b1;
        idx_o    = IDX_W'(i);
        onehot_o = N'(1) << i;
      end
    end
  end
endmodule

// File: rtl/coh_dir_table.sv
module coh_dir_table #(
  parameter int NUM_PROC = 4,
  parameter int NUM_BLK  = 16,
  parameter int BLK_W    = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [BLK_W-1:0]    rd_blk_i,
  output logic [NUM_PROC-1:0] rd_pres_o,
  output logic                rd_dirty_o,
  input  logic                we_i,
  input  logic [BLK_W-1:0]    wr_blk_i,
  input  logic [NUM_PROC-1:0] wr_pres_i,
  input  logic                wr_dirty_i
);
  logic [NUM_PROC-1:0] pres_q  [NUM_BLK];
  logic                dirty_q [NUM_BLK];

  for (genvar b = 0; b < NUM_BLK; b++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pres_q[b]  <= '0;
        dirty_q[b] <= 1'b0;
      end else if (we_i && wr_blk_i == BLK_W'(b)) begin
        pres_q[b]  <= wr_pres_i;
        dirty_q[b] <= wr_dirty_i;
      end
    end
  end

  assign rd_pres_o  = pres_q[rd_blk_i];
  assign rd_dirty_o = dirty_q[rd_blk_i];
endmodule

// File: rtl/coh_line_mem.sv
module coh_line_mem #(
  parameter int NUM_BLK = 16,
  parameter int BLK_W   = 4,
  parameter int DATA_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BLK_W-1:0]  rd_blk_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              we_i,
  input  logic [BLK_W-1:0]  wr_blk_i,
  input  logic [DATA_W-1:0] wr_data_i
);
  logic [DATA_W-1:0] mem_q [NUM_BLK];

  for (genvar b = 0; b < NUM_BLK; b++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[b] <= '0;
      else if (we_i && wr_blk_i == BLK_W'(b)) mem_q[b] <= wr_data_i;
    end
  end

  assign rd_data_o = mem_q[rd_blk_i];
endmodule

// File: rtl/coh_home_dir.sv
module coh_home_dir #(
  parameter int NUM_PROC = 4,
  parameter int NUM_BLK  = 16,
  parameter int DATA_W   = 32,
  localparam int PID_W   = (NUM_PROC > 1) ? $clog2(NUM_PROC) : 1,
  localparam int BLK_W   = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [1:0]        req_op_i,
  input  logic [PID_W-1:0]  req_src_i,
  input  logic [BLK_W-1:0]  req_blk_i,
  input  logic [DATA_W-1:0] req_data_i,
  output logic              msg_valid_o,
  output logic [1:0]        msg_kind_o,
  output logic [PID_W-1:0]  msg_dst_o,
  input  logic              ack_valid_i,
  input  logic [DATA_W-1:0] ack_data_i,
  output logic              rsp_valid_o,
  output logic [PID_W-1:0]  rsp_dst_o,
  output logic [DATA_W-1:0] rsp_data_o
);
  import coh_pkg::*;
  localparam int CNT_W = $clog2(NUM_PROC + 1);

  state_e              state_q;
  op_e                 op_q;
  msg_e                kind_q;
  logic [PID_W-1:0]    src_q;
  logic [BLK_W-1:0]    blk_q;
  logic [DATA_W-1:0]   line_q;
  logic [NUM_PROC-1:0] pend_q;
  logic [CNT_W-1:0]    outst_q;
  logic                recall_q, hold_q, wb_ok_q;

  logic [BLK_W-1:0]    rd_blk;
  logic [NUM_PROC-1:0] pres_rd;
  logic                dirty_rd;
  logic [DATA_W-1:0]   mem_rd;
  logic                dir_we, mem_we;
  logic [NUM_PROC-1:0] dir_wpres;
  logic                dir_wdirty;

  logic                own_found, sel_found;
  logic [PID_W-1:0]    own_idx, sel_idx;
  logic [NUM_PROC-1:0] own_oh, sel_oh;

  assign rd_blk = (state_q == ST_IDLE) ? req_blk_i : blk_q;

  coh_dir_table #(.NUM_PROC(NUM_PROC), .NUM_BLK(NUM_BLK), .BLK_W(BLK_W)) u_dir (
    .clk_i, .rst_ni,
    .rd_blk_i(rd_blk), .rd_pres_o(pres_rd), .rd_dirty_o(dirty_rd),
    .we_i(dir_we), .wr_blk_i(blk_q), .wr_pres_i(dir_wpres), .wr_dirty_i(dir_wdirty)
  );

  coh_line_mem #(.NUM_BLK(NUM_BLK), .BLK_W(BLK_W), .DATA_W(DATA_W)) u_mem (
    .clk_i, .rst_ni,
    .rd_blk_i(rd_blk), .rd_data_o(mem_rd),
    .we_i(mem_we), .wr_blk_i(blk_q), .wr_data_i(line_q)
  );

  // owner of a dirty line is its single sharer
  coh_first_set #(.N(NUM_PROC), .IDX_W(PID_W)) u_owner (
    .vec_i(pres_rd), .found_o(own_found), .idx_o(own_idx), .onehot_o(own_oh)
  );
  coh_first_set #(.N(NUM_PROC), .IDX_W(PID_W)) u_next (
    .vec_i(pend_q), .found_o(sel_found), .idx_o(sel_idx), .onehot_o(sel_oh)
  );

  // request decode
  op_e                 req_op;
  logic [NUM_PROC-1:0] src_oh, tgt;
  msg_e                tgt_kind;
  logic                self_own;

  always_comb begin
    req_op   = op_e'(req_op_i);
    src_oh   = NUM_PROC'(1) << req_src_i;
    self_own = dirty_rd && own_found && (own_idx == req_src_i);
    tgt      = '0;
    tgt_kind = MSG_INV;
    unique case (req_op)
      OP_RD: if (dirty_rd && !self_own) begin
        tgt = own_oh; tgt_kind = MSG_RCL_SH;
      end
      OP_WR: if (dirty_rd && !self_own) begin
        tgt = own_oh; tgt_kind = MSG_RCL_INV;
      end else if (!dirty_rd) begin
        tgt = pres_rd & ~src_oh; tgt_kind = MSG_INV;
      end
      default: ;
    endcase
  end

  // message issue and reply accounting
  logic [NUM_PROC-1:0] pend_nxt;
  logic [CNT_W-1:0]    outst_nxt;

  always_comb begin
    pend_nxt  = sel_found ? (pend_q & ~sel_oh) : pend_q;
    outst_nxt = ack_valid_i ? outst_q - CNT_W'(1) : outst_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      op_q     <= OP_RD;
      kind_q   <= MSG_INV;
      src_q    <= '0;
      blk_q    <= '0;
      line_q   <= '0;
      pend_q   <= '0;
      outst_q  <= '0;
      recall_q <= 1'b0;
      hold_q   <= 1'b0;
      wb_ok_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          op_q     <= req_op;
          kind_q   <= tgt_kind;
          src_q    <= req_src_i;
          blk_q    <= req_blk_i;
          line_q   <= (req_op == OP_WB) ? req_data_i : mem_rd;
          pend_q   <= tgt;
          outst_q  <= CNT_W'($countones(tgt));
          recall_q <= (tgt != '0) && (tgt_kind != MSG_INV);
          hold_q   <= self_own;
          wb_ok_q  <= self_own && (pres_rd == src_oh);
          state_q  <= (tgt != '0) ? ST_BUSY : ST_DONE;
        end
        ST_BUSY: begin
          pend_q  <= pend_nxt;
          outst_q <= outst_nxt;
          if (ack_valid_i && recall_q) line_q <= ack_data_i;
          if (pend_nxt == '0 && outst_nxt == '0) state_q <= ST_DONE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // directory and memory update on completion
  logic [NUM_PROC-1:0] src_q_oh;
  assign src_q_oh = NUM_PROC'(1) << src_q;

  always_comb begin
    dir_we     = 1'b0;
    mem_we     = 1'b0;
    dir_wpres  = pres_rd;
    dir_wdirty = dirty_rd;
    if (state_q == ST_DONE) begin
      unique case (op_q)
        OP_RD: if (!hold_q) begin
          dir_we = 1'b1; mem_we = recall_q;
          dir_wpres = pres_rd | src_q_oh; dir_wdirty = 1'b0;
        end
        OP_WR: begin
          dir_we = 1'b1; mem_we = recall_q;
          dir_wpres = src_q_oh; dir_wdirty = 1'b1;
        end
        default: if (wb_ok_q) begin
          dir_we = 1'b1; mem_we = 1'b1;
          dir_wpres = pres_rd & ~src_q_oh; dir_wdirty = 1'b0;
        end
      endcase
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign msg_valid_o = (state_q == ST_BUSY) && sel_found;
  assign msg_kind_o  = kind_q;
  assign msg_dst_o   = sel_idx;
  assign rsp_valid_o = (state_q == ST_DONE);
  assign rsp_dst_o   = src_q;
  assign rsp_data_o  = line_q;
endmodule

// File: rtl/coh_home_dir_chk.sv
module coh_home_dir_chk #(
  parameter int NUM_PROC = 4,
  parameter int PID_W    = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic             msg_valid_o,
  input logic [1:0]       msg_kind_o,
  input logic [PID_W-1:0] msg_dst_o,
  input logic             ack_valid_i,
  input logic             rsp_valid_o
);
  // messages sent minus replies received
  logic [7:0] owed_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) owed_q <= '0;
    else owed_q <= owed_q + 8'(msg_valid_o) - 8'(ack_valid_i);
  end

  assert_busy_after_accept_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);
  assert_idle_after_rsp_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> (req_ready_o && !rsp_valid_o));
  assert_rsp_after_replies_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (owed_q == 8'd0));
  assert_msg_while_busy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o |-> (!req_ready_o && !rsp_valid_o && 32'(msg_dst_o) < NUM_PROC));
  assert_msg_ascending_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_o && $past(msg_valid_o)) |-> (msg_dst_o > $past(msg_dst_o)));
  assert_recall_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_o && msg_kind_o != 2'd0) |=> !msg_valid_o);
endmodule

bind coh_home_dir coh_home_dir_chk #(.NUM_PROC(NUM_PROC), .PID_W(PID_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
  .msg_valid_o(msg_valid_o), .msg_kind_o(msg_kind_o), .msg_dst_o(msg_dst_o),
  .ack_valid_i(ack_valid_i), .rsp_valid_o(rsp_valid_o)
);

// File: tb/sim_coh_home_dir.sv
module sim_coh_home_dir;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4, NB = 16, DW = 32;
  localparam int RD = 0, WR = 1, WB = 2;
  localparam int K_INV = 0, K_SH = 1, K_RINV = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [1:0] req_op = '0;
  logic [1:0] req_src = '0;
  logic [3:0] req_blk = '0;
  logic [DW-1:0] req_data = '0;
  logic msg_valid; logic [1:0] msg_kind; logic [1:0] msg_dst;
  logic ack_valid = 1'b0; logic [DW-1:0] ack_data = '0;
  logic rsp_valid; logic [1:0] rsp_dst; logic [DW-1:0] rsp_data;

  always #(CLK_PERIOD / 2) clk = ~clk;

  coh_home_dir #(.NUM_PROC(NP), .NUM_BLK(NB), .DATA_W(DW)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_op_i(req_op),
    .req_src_i(req_src), .req_blk_i(req_blk), .req_data_i(req_data),
    .msg_valid_o(msg_valid), .msg_kind_o(msg_kind), .msg_dst_o(msg_dst),
    .ack_valid_i(ack_valid), .ack_data_i(ack_data),
    .rsp_valid_o(rsp_valid), .rsp_dst_o(rsp_dst), .rsp_data_o(rsp_data)
  );

  int n_chk = 0, n_err = 0;
  int n_msg, rsp_cyc, last_ack;
  int m_dst[8], m_kind[8];
  logic [DW-1:0] got_data;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one request; replies to messages in send order, starting no earlier than ack_delay
  task automatic txn(input int op, input int src, input int blk, input logic [DW-1:0] wdata,
                     input logic [DW-1:0] rdata, input int ack_delay);
    bit got = 0, busy_ok = 1;
    int acks = 0;
    n_msg = 0; rsp_cyc = -1; last_ack = -1; got_data = '0;
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'(op); req_src = 2'(src); req_blk = 4'(blk); req_data = wdata;
    @(negedge clk);
    req_valid = 1'b0;
    for (int cyc = 1; cyc < 100 && !got; cyc++) begin
      ack_valid = 1'b0;
      if (rsp_valid) begin
        got = 1; rsp_cyc = cyc; got_data = rsp_data;
        chk(rsp_dst == 2'(src), "R10 answer destination", rsp_dst, src);
      end else if (req_ready) busy_ok = 0;
      if (msg_valid) begin
        if (n_msg < 8) begin m_dst[n_msg] = msg_dst; m_kind[n_msg] = msg_kind; end
        n_msg++;
      end
      if (!got && acks < n_msg && cyc >= ack_delay) begin
        ack_valid = 1'b1; ack_data = rdata; last_ack = cyc; acks++;
      end
      if (!got) @(negedge clk);
    end
    ack_valid = 1'b0;
    chk(got, "R10 answer given", got, 1);
    chk(busy_ok, "R10 ready low while busy", busy_ok, 1);
    if (got) begin
      @(negedge clk);
      chk(req_ready && !rsp_valid, "R10 idle after single-cycle answer", {req_ready, rsp_valid}, 2'b10);
    end
  endtask

  task automatic exp_msgs(input string tag, input int n, input int kind,
                          input int d0, input int d1, input int d2);
    int d[3];
    d[0] = d0; d[1] = d1; d[2] = d2;
    chk(n_msg == n, {tag, " message count"}, n_msg, n);
    for (int i = 0; i < n && i < n_msg; i++) begin
      chk(m_dst[i] == d[i], {tag, " message destination"}, m_dst[i], d[i]);
      chk(m_kind[i] == kind, {tag, " message kind"}, m_kind[i], kind);
    end
  endtask

  task automatic t_reset;
    chk(req_ready && !rsp_valid && !msg_valid, "R1 outputs after reset",
        {req_ready, rsp_valid, msg_valid}, 3'b100);
    txn(RD, 0, 3, '0, '0, 0);
    exp_msgs("R1 R2 clean read", 0, K_INV, 0, 0, 0);
    chk(got_data == '0, "R1 memory zero after reset", got_data, 0);
  endtask

  task automatic t_share_then_write;
    for (int p = 1; p < 4; p++) begin
      txn(RD, p, 5, '0, '0, 0);
      exp_msgs("R2 clean read by sharer", 0, K_INV, 0, 0, 0);
      chk(got_data == '0, "R2 read data", got_data, 0);
    end
    txn(WR, 2, 5, '0, '0, 6);
    exp_msgs("R4 invalidate sharers", 2, K_INV, 1, 3, 0);
    chk(rsp_cyc == last_ack + 1, "R5 answer after last reply", rsp_cyc, last_ack + 1);
    chk(got_data == '0, "R4 write data", got_data, 0);
  endtask

  task automatic t_recall_share;
    txn(RD, 0, 5, '0, 32'hA5A5_0001, 0);
    exp_msgs("R3 R6 recall from writer", 1, K_SH, 2, 0, 0);
    chk(got_data == 32'hA5A5_0001, "R3 recalled data", got_data, 32'hA5A5_0001);
    txn(RD, 1, 5, '0, '0, 0);
    exp_msgs("R3 clean after recall", 0, K_INV, 0, 0, 0);
    chk(got_data == 32'hA5A5_0001, "R3 memory updated", got_data, 32'hA5A5_0001);
    txn(WR, 3, 5, '0, '0, 2);
    exp_msgs("R3 old owner kept as sharer", 3, K_INV, 0, 1, 2);
  endtask

  task automatic t_recall_inv;
    txn(WR, 1, 5, '0, 32'h1234_5678, 3);
    exp_msgs("R7 recall-invalidate owner", 1, K_RINV, 3, 0, 0);
    chk(got_data == 32'h1234_5678, "R7 recalled data", got_data, 32'h1234_5678);
    txn(WR, 0, 5, '0, 32'h0BAD_F00D, 0);
    exp_msgs("R7 R6 ownership moved", 1, K_RINV, 1, 0, 0);
    chk(got_data == 32'h0BAD_F00D, "R7 second recall data", got_data, 32'h0BAD_F00D);
  endtask

  task automatic t_writeback;
    txn(WB, 0, 5, 32'hCAFE_0000, '0, 0);
    exp_msgs("R8 write-back silent", 0, K_INV, 0, 0, 0);
    txn(RD, 2, 5, '0, '0, 0);
    exp_msgs("R8 clean after write-back", 0, K_INV, 0, 0, 0);
    chk(got_data == 32'hCAFE_0000, "R8 write-back stored", got_data, 32'hCAFE_0000);
    txn(WR, 1, 5, '0, '0, 0);
    exp_msgs("R8 owner dropped from sharers", 1, K_INV, 2, 0, 0);
  endtask

  task automatic t_ignored_wb;
    txn(WB, 3, 9, 32'hDEAD_BEEF, '0, 0);
    txn(RD, 0, 9, '0, '0, 0);
    exp_msgs("R9 clean block", 0, K_INV, 0, 0, 0);
    chk(got_data == '0, "R9 clean block unchanged", got_data, 0);
    txn(WB, 3, 5, 32'h1111_1111, '0, 0);
    txn(RD, 2, 5, '0, 32'h2222_2222, 0);
    exp_msgs("R9 owner unchanged", 1, K_SH, 1, 0, 0);
    chk(got_data == 32'h2222_2222, "R9 recalled data", got_data, 32'h2222_2222);
    txn(RD, 3, 5, '0, '0, 0);
    chk(got_data == 32'h2222_2222, "R9 stray data not stored", got_data, 32'h2222_2222);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_share_then_write();
    t_recall_share();
    t_recall_inv();
    t_writeback();
    t_ignored_wb();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL R10 watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule